// File: doc/BRIEF.md
# Boot Flash Write-Protection Gate

This block sits between a flash access requester and the boot-firmware flash. For every access request it decides, one cycle later, whether the access may proceed. It combines three protection layers. The first is a write-enable bit whose 0-to-1 transition can be trapped to system management software through an SMI request. The second is a mode in which writes to the firmware region are honoured only while the processor runs in SMM. The third is a set of address ranges, each of which can block writes, reads or both, and which can be frozen by a lockdown bit until reset.

Software programs the block through a small register port. There are eight 32-bit words, selected by a 3-bit address. Word 0 is the control byte. Word 1 is the status word. Words 2 to 6 are the range words 0 to 4. Word 7 holds the SMI enables. The firmware region bounds are static configuration inputs. The top-swap status bit and the two SMI-enable lock bits also come from outside the block.

Top module: `flash_wp_gate`

## Requirements
- R1: After reset every register word reads 0, except control bit 4, which mirrors `ts_status_i`. Grant, deny and the SMI request are all low.
- R2: Control word layout: bit 0 is write enable (WE), bit 1 is lock-enable (LE), bit 4 is the read-only top-swap status, and bit 5 is SMM-only write mode (SMMW). All other bits read 0 and ignore writes.
- R3: Once LE or SMMW is 1, software cannot clear it by writing 0. Only reset clears them.
- R4: A control write is a trapped write when LE was already 1, WE was 0, and the write sets bit 0. For a trapped write, `smi_req_o` is high for exactly the cycle after the write, provided both SMI enables are 1. For any other write, or when either enable is 0, it stays low.
- R5: Word 7 holds the global SMI enable at bit 0 and the TCO SMI enable at bit 1. While `gbl_smi_lock_i` (or `tco_smi_lock_i`) is high, writes leave the corresponding bit unchanged.
- R6: A write whose address lies inside [`bios_base_i`, `bios_limit_i`] is denied while WE is 0.
- R7: While SMMW is 1, a write inside the firmware region is granted only if `in_smm_i` is 1 and WE is 1.
- R8: Reads, and writes outside the firmware region, are not affected by WE or SMMW.
- R9: Range word fields are base at bits 12:0, read-protect at bit 15, limit at bits 28:16 and write-protect at bit 31. Base and limit are 4 KiB page numbers, and the limit is inclusive. A write that hits a range with write-protect set is denied, and so is a read that hits a range with read-protect set, in any processor mode. The other bits read 0. A range whose limit is below its base hits nothing. For example, 0x87FF0780 blocks writes to 0x780000 through 0x7FFFFF.
- R10: Writing 1 to status bit 0 sets lockdown. From then until reset, writes to the range words are ignored and the lockdown bit cannot be cleared.
- R11: The result of each access request appears one cycle later, as exactly one of `acc_grant_o` or `acc_deny_o` high for one cycle. Both stay low in cycles without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| ts_status_i | input | 1 | Top-swap status shown at control bit 4 |
| gbl_smi_lock_i | input | 1 | Freezes the global SMI enable |
| tco_smi_lock_i | input | 1 | Freezes the TCO SMI enable |
| bios_base_i | input | 25 | First byte of the firmware region |
| bios_limit_i | input | 25 | Last byte of the firmware region |
| acc_valid_i | input | 1 | Access request |
| acc_write_i | input | 1 | 1 for a write, 0 for a read |
| acc_addr_i | input | 25 | Flash byte address |
| in_smm_i | input | 1 | Processor is in SMM |
| acc_grant_o | output | 1 | Access allowed, one cycle after the request |
| acc_deny_o | output | 1 | Access refused, one cycle after the request |
| smi_req_o | output | 1 | One-cycle SMI request |

## Verification
Register writes take effect at the clock edge that captures them. Read data is combinational, so the bench reads each word back in the cycle after the write. Both an access verdict and an SMI pulse come out one register stage after their cause. The bench drives every stimulus on the falling edge and samples on the next falling edge, which puts the sample after exactly one rising edge. For SMI pulses it also samples one cycle later to confirm the pulse has ended. The access sweeps walk addresses across the firmware region and the range edges, for every combination of WE, SMMW and SMM state, and compare each verdict with an expected value the bench computes from the settings it has written.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  localparam int PAGE_SH  = 12;
  localparam int PG_W     = 13;
  localparam int ADDR_W   = PG_W + PAGE_SH;
  localparam int REG_AW   = 3;
  localparam int DATA_W   = 32;
  localparam int MAX_PR   = 5;

  // register word map
  localparam logic [REG_AW-1:0] A_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] A_STAT  = 3'd1;
  localparam int                A_PR0   = 2;
  localparam logic [REG_AW-1:0] A_SMIEN = 3'd7;

  // control byte bit positions
  localparam int C_WE   = 0;
  localparam int C_LE   = 1;
  localparam int C_TS   = 4;
  localparam int C_SMMW = 5;

  // range word bit positions
  localparam int PR_RP  = 15;
  localparam int PR_WP  = 31;
  localparam int PR_LIM = 16;

  typedef struct packed {
    logic            wp;
    logic [PG_W-1:0] limit;
    logic            rp;
    logic [PG_W-1:0] base;
  } pr_t;

  function automatic logic [DATA_W-1:0] pr_to_word(pr_t p);
    return {p.wp, 2'b00, p.limit, p.rp, 2'b00, p.base};
  endfunction
endpackage

// File: rtl/fwp_ctrl_regs.sv
module fwp_ctrl_regs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_we_i,
  input  logic smien_we_i,
  input  logic we_bit_i,
  input  logic le_bit_i,
  input  logic smmw_bit_i,
  input  logic gbl_bit_i,
  input  logic tco_bit_i,
  input  logic gbl_lock_i,
  input  logic tco_lock_i,
  output logic we_o,
  output logic le_o,
  output logic smmw_o,
  output logic gbl_en_o,
  output logic tco_en_o,
  output logic smi_req_o
);
  logic we_q, le_q, smmw_q, gbl_q, tco_q, smi_q;
  logic trap;

  // 0->1 on write enable while lock-enable already set
  assign trap = ctrl_we_i && le_q && !we_q && we_bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b0;
      le_q   <= 1'b0;
      smmw_q <= 1'b0;
      gbl_q  <= 1'b0;
      tco_q  <= 1'b0;
      smi_q  <= 1'b0;
    end else begin
      smi_q <= trap && gbl_q && tco_q;
      if (ctrl_we_i) begin
        we_q   <= we_bit_i;
        le_q   <= le_q | le_bit_i;
        smmw_q <= smmw_q | smmw_bit_i;
      end
      if (smien_we_i) begin
        if (!gbl_lock_i) gbl_q <= gbl_bit_i;
        if (!tco_lock_i) tco_q <= tco_bit_i;
      end
    end
  end

  assign we_o      = we_q;
  assign le_o      = le_q;
  assign smmw_o    = smmw_q;
  assign gbl_en_o  = gbl_q;
  assign tco_en_o  = tco_q;
  assign smi_req_o = smi_q;

  AST_LE_STICKY:   assert property (@(posedge clk_i) disable iff (!rst_ni) le_q |=> le_q);            // R3
  AST_SMMW_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) smmw_q |=> smmw_q);        // R3
  AST_SMI_ONE_CYC: assert property (@(posedge clk_i) disable iff (!rst_ni) smi_req_o |=> !smi_req_o); // R4
  AST_SMI_CAUSE:   assert property (@(posedge clk_i) disable iff (!rst_ni)
                     smi_req_o |-> $past(ctrl_we_i && we_bit_i));                                     // R4
  AST_GBL_FROZEN:  assert property (@(posedge clk_i) disable iff (!rst_ni) gbl_lock_i |=> $stable(gbl_q)); // R5
  AST_TCO_FROZEN:  assert property (@(posedge clk_i) disable iff (!rst_ni) tco_lock_i |=> $stable(tco_q)); // R5
endmodule

// File: rtl/fwp_range_bank.sv
module fwp_range_bank
  import fwp_pkg::*;
#(
  parameter int NUM_PR = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PR-1:0]     pr_we_i,
  input  pr_t                   pr_wval_i,
  input  logic                  stat_we_i,
  input  logic                  lock_bit_i,
  input  logic [PG_W-1:0]       page_i,
  output logic                  lock_o,
  output pr_t  [NUM_PR-1:0]     pr_o,
  output logic [NUM_PR-1:0]     wp_hit_o,
  output logic [NUM_PR-1:0]     rp_hit_o
);
  logic lock_q;
  pr_t [NUM_PR-1:0] pr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  lock_q <= 1'b0;
    else if (stat_we_i && !lock_q) lock_q <= lock_bit_i;
  end

  for (genvar g = 0; g < NUM_PR; g++) begin : g_pr
    logic in_rng;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       pr_q[g] <= '0;
      else if (pr_we_i[g] && !lock_q)    pr_q[g] <= pr_wval_i;
    end
    assign in_rng      = (page_i >= pr_q[g].base) && (page_i <= pr_q[g].limit);
    assign wp_hit_o[g] = in_rng && pr_q[g].wp;
    assign rp_hit_o[g] = in_rng && pr_q[g].rp;
  end

  assign lock_o = lock_q;
  assign pr_o   = pr_q;

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) lock_q |=> lock_q);         // R10
  AST_PR_FROZEN:   assert property (@(posedge clk_i) disable iff (!rst_ni) lock_q |=> $stable(pr_q));  // R10
endmodule

// File: rtl/fwp_access_check.sv
module fwp_access_check
  import fwp_pkg::*;
#(
  parameter int NUM_PR = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              in_smm_i,
  input  logic [ADDR_W-1:0] bios_base_i,
  input  logic [ADDR_W-1:0] bios_limit_i,
  input  logic              we_i,
  input  logic              smmw_i,
  input  logic [NUM_PR-1:0] wp_hit_i,
  input  logic [NUM_PR-1:0] rp_hit_i,
  output logic              grant_o,
  output logic              deny_o
);
  logic in_bios, bios_block, range_block, refuse;
  logic grant_q, deny_q;

  assign in_bios     = (acc_addr_i >= bios_base_i) && (acc_addr_i <= bios_limit_i);
  assign bios_block  = acc_write_i && in_bios && (!we_i || (smmw_i && !in_smm_i));
  assign range_block = acc_write_i ? |wp_hit_i : |rp_hit_i;
  assign refuse      = bios_block || range_block;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q <= 1'b0;
      deny_q  <= 1'b0;
    end else begin
      grant_q <= acc_valid_i && !refuse;
      deny_q  <= acc_valid_i && refuse;
    end
  end

  assign grant_o = grant_q;
  assign deny_o  = deny_q;

  AST_ONE_VERDICT: assert property (@(posedge clk_i) disable iff (!rst_ni) !(grant_o && deny_o));  // R11
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
                     (grant_o || deny_o) |-> $past(acc_valid_i));                                  // R11
  AST_SMMW_BLOCK:  assert property (@(posedge clk_i) disable iff (!rst_ni)
                     (acc_valid_i && acc_write_i && in_bios && smmw_i && !in_smm_i) |=> deny_o);   // R7
  AST_WE_BLOCK:    assert property (@(posedge clk_i) disable iff (!rst_ni)
                     (acc_valid_i && acc_write_i && in_bios && !we_i) |=> deny_o);                 // R6
endmodule

// File: rtl/flash_wp_gate.sv
module flash_wp_gate
  import fwp_pkg::*;
#(
  parameter int NUM_PR = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              ts_status_i,
  input  logic              gbl_smi_lock_i,
  input  logic              tco_smi_lock_i,
  input  logic [24:0]       bios_base_i,
  input  logic [24:0]       bios_limit_i,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [24:0]       acc_addr_i,
  input  logic              in_smm_i,
  output logic              acc_grant_o,
  output logic              acc_deny_o,
  output logic              smi_req_o
);
  localparam int LAST_PR = A_PR0 + NUM_PR - 1;

  logic we, le, smmw, gbl_en, tco_en, lock;
  logic ctrl_we, smien_we, stat_we;
  logic [NUM_PR-1:0] pr_we, wp_hit, rp_hit;
  pr_t  [NUM_PR-1:0] pr_cur;
  pr_t               pr_wval;
  logic unused_wdata;

  assign ctrl_we  = reg_we_i && (reg_addr_i == A_CTRL);
  assign stat_we  = reg_we_i && (reg_addr_i == A_STAT);
  assign smien_we = reg_we_i && (reg_addr_i == A_SMIEN);

  for (genvar g = 0; g < NUM_PR; g++) begin : g_dec
    assign pr_we[g] = reg_we_i && (int'(reg_addr_i) == A_PR0 + g);
  end

  assign pr_wval.wp    = reg_wdata_i[PR_WP];
  assign pr_wval.limit = reg_wdata_i[PR_LIM +: PG_W];
  assign pr_wval.rp    = reg_wdata_i[PR_RP];
  assign pr_wval.base  = reg_wdata_i[PG_W-1:0];
  assign unused_wdata  = ^{reg_wdata_i[30:29], reg_wdata_i[14:13], reg_wdata_i[7:6],
                           reg_wdata_i[4:2]};

  fwp_ctrl_regs u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_we_i  (ctrl_we),
    .smien_we_i (smien_we),
    .we_bit_i   (reg_wdata_i[C_WE]),
    .le_bit_i   (reg_wdata_i[C_LE]),
    .smmw_bit_i (reg_wdata_i[C_SMMW]),
    .gbl_bit_i  (reg_wdata_i[0]),
    .tco_bit_i  (reg_wdata_i[1]),
    .gbl_lock_i (gbl_smi_lock_i),
    .tco_lock_i (tco_smi_lock_i),
    .we_o       (we),
    .le_o       (le),
    .smmw_o     (smmw),
    .gbl_en_o   (gbl_en),
    .tco_en_o   (tco_en),
    .smi_req_o  (smi_req_o)
  );

  fwp_range_bank #(.NUM_PR(NUM_PR)) u_rng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pr_we_i    (pr_we),
    .pr_wval_i  (pr_wval),
    .stat_we_i  (stat_we),
    .lock_bit_i (reg_wdata_i[0]),
    .page_i     (acc_addr_i[ADDR_W-1:PAGE_SH]),
    .lock_o     (lock),
    .pr_o       (pr_cur),
    .wp_hit_o   (wp_hit),
    .rp_hit_o   (rp_hit)
  );

  fwp_access_check #(.NUM_PR(NUM_PR)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .acc_valid_i  (acc_valid_i),
    .acc_write_i  (acc_write_i),
    .acc_addr_i   (acc_addr_i),
    .in_smm_i     (in_smm_i),
    .bios_base_i  (bios_base_i),
    .bios_limit_i (bios_limit_i),
    .we_i         (we),
    .smmw_i       (smmw),
    .wp_hit_i     (wp_hit),
    .rp_hit_i     (rp_hit),
    .grant_o      (acc_grant_o),
    .deny_o       (acc_deny_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL:  begin
        reg_rdata_o[C_WE]   = we;
        reg_rdata_o[C_LE]   = le;
        reg_rdata_o[C_TS]   = ts_status_i;
        reg_rdata_o[C_SMMW] = smmw;
      end
      A_STAT:  reg_rdata_o[0] = lock;
      A_SMIEN: reg_rdata_o[1:0] = {tco_en, gbl_en};
      default: begin
        for (int i = 0; i < NUM_PR; i++)
          if (int'(reg_addr_i) == A_PR0 + i) reg_rdata_o = pr_to_word(pr_cur[i]);
      end
    endcase
  end

  initial begin
    AST_PR_COUNT: assert (NUM_PR >= 1 && NUM_PR <= MAX_PR && LAST_PR < A_SMIEN); // R9
  end
endmodule

// File: tb/sim_flash_wp_gate.sv
module sim_flash_wp_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ts = 1'b0, gbl_lk = 1'b0, tco_lk = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0, in_smm = 1'b0;
  logic [24:0] acc_addr = '0;
  logic        grant, deny, smi;
  localparam int BB = 32'h500000;
  localparam int BL = 32'h7FFFFF;

  int tests = 0, fails = 0;
  bit done = 0;

  // bench view of programmed state
  int  sh_base[5], sh_lim[5];
  bit  sh_wp[5], sh_rp[5];
  bit  sh_we = 0, sh_smmw = 0;

  always #4 clk = ~clk;

  flash_wp_gate u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .ts_status_i(ts),
    .gbl_smi_lock_i(gbl_lk), .tco_smi_lock_i(tco_lk),
    .bios_base_i(BB[24:0]), .bios_limit_i(BL[24:0]),
    .acc_valid_i(acc_valid), .acc_write_i(acc_write), .acc_addr_i(acc_addr),
    .in_smm_i(in_smm), .acc_grant_o(grant), .acc_deny_o(deny), .smi_req_o(smi));

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int ad, input logic [31:0] d, output logic s);
    @(negedge clk); reg_we = 1; reg_addr = ad[2:0]; reg_wdata = d;
    @(negedge clk); reg_we = 0; s = smi;
  endtask

  task automatic rd(input int ad, output logic [31:0] v);
    @(negedge clk); reg_addr = ad[2:0]; #1; v = reg_rdata;
  endtask

  task automatic acc(input int a, input bit w, input bit smm, output logic [1:0] gd);
    @(negedge clk); acc_valid = 1; acc_write = w; acc_addr = a[24:0]; in_smm = smm;
    @(negedge clk); acc_valid = 0; gd = {grant, deny};
  endtask

  task automatic set_pr(input int i, input int b, input int l, input bit w, input bit r);
    logic s;
    wr(2 + i, {w, 2'b00, l[12:0], r, 2'b00, b[12:0]}, s);
    sh_base[i] = b; sh_lim[i] = l; sh_wp[i] = w; sh_rp[i] = r;
  endtask

  function automatic bit exp_deny(int a, bit w, bit smm);
    int pg = a >>> 12;
    bit d = 0;
    for (int i = 0; i < 5; i++)
      if (pg >= sh_base[i] && pg <= sh_lim[i] && (w ? sh_wp[i] : sh_rp[i])) d = 1;
    if (w && a >= BB && a <= BL && (!sh_we || (sh_smmw && !smm))) d = 1;
    return d;
  endfunction

  function automatic int sweep_addr(int k);
    case (k)
      99:  return 32'h4FFFFF;
      100: return 32'h500000;
      101: return 32'h77FFFF;
      102: return 32'h7FFFFF;
      103: return 32'h800000;
      104: return 32'h7FF000;
      default: return 32'h4F8000 + k * 32'h8000;
    endcase
  endfunction

  task automatic sweep(input string tag);
    logic [1:0] gd;
    for (int smm = 0; smm < 2; smm++)
      for (int k = 0; k < 105; k++)
        for (int w = 0; w < 2; w++) begin
          int a = sweep_addr(k);
          acc(a, w[0], smm[0], gd);
          chk(tag, {30'd0, gd}, exp_deny(a, w[0], smm[0]) ? 32'd1 : 32'd2);
        end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic s;
    logic [1:0] gd;
    for (int i = 0; i < 5; i++) begin sh_base[i] = 0; sh_lim[i] = 0; sh_wp[i] = 0; sh_rp[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    for (int ad = 0; ad < 8; ad++) begin rd(ad, v); chk("R1 reset word", v, 0); end
    chk("R1 outputs idle", {29'd0, grant, deny, smi}, 0);

    // R2: control layout, top swap read-only
    ts = 1; rd(0, v); chk("R2 ts mirror", v, 32'h10);
    wr(0, 32'hDC, s); rd(0, v); chk("R2 reserved bits ignored", v, 32'h10);
    wr(0, 32'h01, s); rd(0, v); chk("R2 WE bit", v, 32'h11);
    ts = 0; wr(0, 32'h00, s); rd(0, v); chk("R2 WE cleared", v, 0);

    // R9: range word fields
    wr(5, 32'hFFFF_FFFF, s); rd(5, v); chk("R9 field mask", v, 32'h9FFF9FFF);
    wr(5, 0, s);
    set_pr(0, 32'h780, 32'h7FF, 1, 0);
    rd(2, v); chk("R9 readback", v, 32'h87FF0780);
    set_pr(1, 32'h10, 32'h11, 0, 1);
    set_pr(2, 32'h20, 32'h0, 1, 1);  // limit below base: inert

    // R6 R8 R9 with SMMW off, WE off then on
    sh_we = 0; sweep("R6_R8_R9 WE=0");
    wr(0, 32'h01, s); sh_we = 1; sweep("R8_R9 WE=1");
    // R7 with SMMW on
    wr(0, 32'h20, s); sh_we = 0; sh_smmw = 1; sweep("R7_R9 SMMW WE=0");
    wr(0, 32'h21, s); sh_we = 1; sweep("R7_R9 SMMW WE=1");

    // R9 low ranges: read protect and inverted range
    for (int a = 32'hE000; a <= 32'h24000; a += 32'h1000)
      for (int w = 0; w < 2; w++) begin
        acc(a, w[0], 0, gd);
        chk("R9 low sweep", {30'd0, gd}, exp_deny(a, w[0], 0) ? 32'd1 : 32'd2);
      end

    // R11: no verdict without a request
    @(negedge clk); chk("R11 idle cycle", {30'd0, grant, deny}, 0);

    // R5: SMI enable register and locks
    wr(7, 3, s); rd(7, v); chk("R5 enables", v, 3);
    gbl_lk = 1; wr(7, 0, s); rd(7, v); chk("R5 global lock", v, 1);
    gbl_lk = 0; wr(7, 3, s);
    tco_lk = 1; wr(7, 0, s); rd(7, v); chk("R5 tco lock", v, 2);
    tco_lk = 0; wr(7, 3, s); rd(7, v); chk("R5 restore", v, 3);

    // R4: trap behaviour
    wr(0, 32'h22, s); chk("R4 no trap while LE was 0", s, 0);
    wr(0, 32'h23, s); chk("R4 trap pulse", s, 1);
    @(negedge clk); chk("R4 pulse ends", smi, 0);
    wr(0, 32'h23, s); chk("R4 WE already 1", s, 0);
    wr(0, 32'h22, s); chk("R4 clearing WE", s, 0);
    wr(7, 1, s);
    wr(0, 32'h23, s); chk("R4 TCO enable off", s, 0);
    wr(0, 32'h22, s); wr(7, 2, s);
    wr(0, 32'h23, s); chk("R4 global enable off", s, 0);
    wr(7, 3, s); wr(0, 32'h22, s);

    // R3: sticky bits
    wr(0, 32'h00, s); rd(0, v); chk("R3 LE and SMMW sticky", v, 32'h22);

    // R10: lockdown
    wr(1, 1, s); rd(1, v); chk("R10 lock set", v, 1);
    wr(2, 0, s); rd(2, v); chk("R10 range frozen", v, 32'h87FF0780);
    wr(1, 0, s); rd(1, v); chk("R10 lock sticky", v, 1);
    acc(32'h780000, 1, 1, gd); chk("R10 range still protects", {30'd0, gd}, 1);

    // R1: reset clears everything
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    rd(1, v); chk("R1 lock cleared by reset", v, 0);
    rd(0, v); chk("R1 control cleared by reset", v, 0);
    rd(2, v); chk("R1 range cleared by reset", v, 0);

    finish_run();
  end
endmodule